// File: doc/BRIEF.md
# PWM Compare Unit with Double-Buffered Threshold

This block is the threshold stage of one PWM generator channel. Software writes a 16-bit threshold through a 32-bit register port. The write lands in a shadow copy. The comparator works only on a separate active copy, which takes the shadow value at a counter-zero event. The active copy is compared against the running counter, and a one-cycle match pulse goes out to the waveform-shaping and interrupt logic that sits downstream.

Two commit policies are available, selected per unit. In immediate policy, a pending value moves to the active copy at the next counter-zero cycle. In synchronous policy, the move waits for a chip-wide update request. That request is held until the following counter-zero cycle. A threshold larger than the counter's reload value can never match. Rewriting the register before a commit replaces the pending value.

Top module: `pwm_cmp_unit`

## Requirements
- R1: A write stores `wr_data[15:0]` as the threshold. Bits 31:16 of `rd_data` always read 0, and bits 31:16 of `wr_data` have no effect.
- R2: Synchronous reset (`rst`=1 at a rising edge) clears the shadow value, the active value, the pending synchronous request and `match_pulse` to 0.
- R3: `rd_data[15:0]` returns the most recently written value from the cycle after the write, whether or not that value is active yet.
- R4: `match_pulse` is 1 in the cycle after a clock edge at which `cnt_en`=1, the active value equals `cnt_val`, and the active value is at most `cnt_load`. Otherwise it is 0.
- R5: If the active value is greater than `cnt_load`, no pulse is produced. Equality with `cnt_load` still allows a match.
- R6: While `cnt_en`=0, no pulse is produced.
- R7: With `upd_sync_mode`=0 (immediate), a pending value becomes active at the first edge with `cnt_zero`=1. The active value never changes at an edge where `cnt_zero`=0.
- R8: With `upd_sync_mode`=1 (synchronous), a `cnt_zero` edge commits a pending value only if a synchronous request is latched or `glb_sync_req` is 1 at that edge. Otherwise the active value is kept.
- R9: A `glb_sync_req` pulse is held as pending until the next `cnt_zero` edge, which clears it whether or not anything committed.
- R10: A second write before the commit replaces the first. The first value never becomes active.
- R11: A write at the same edge as a committing `cnt_zero` commits the value written at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, threshold in bits 15:0 |
| rd_data | output | 32 | Readback of the shadow threshold, upper bits zero |
| upd_sync_mode | input | 1 | 0 = immediate commit, 1 = commit only after a synchronous request |
| glb_sync_req | input | 1 | Chip-wide synchronous update request pulse |
| cnt_en | input | 1 | Counter running; qualifies matches |
| cnt_val | input | 16 | Current counter value |
| cnt_load | input | 16 | Counter reload value |
| cnt_zero | input | 1 | Counter is at zero this cycle |
| match_pulse | output | 1 | Registered one-cycle match pulse |

## Verification
Some rules are checked on every cycle by assertions:
- reset clearing of both outputs;
- readback following a write;
- silence while the counter is stopped or above the reload value;
- the active value moving only at counter-zero cycles;
- the active value equal to the readback after an immediate-policy zero.

Other behaviour only shows up in the bench's ordered scenarios, because it depends on history: whether a synchronous request was latched or cleared, whether an overwritten value was ever active, and which value a same-cycle write and commit selects.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  // Commit policy selected by the per-unit mode input.
  typedef enum logic {
    UPD_IMMEDIATE = 1'b0,
    UPD_SYNC      = 1'b1
  } upd_mode_e;

  localparam int unsigned CMP_W_DEF = 16;
  localparam int unsigned REG_W_DEF = 32;

endpackage

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_val,
  input  logic             commit,
  output logic [CMP_W-1:0] shadow_q,
  output logic             dirty_q
);

  // Holds the last written threshold.
  // dirty_q is set while that value has not yet been moved to the active copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      dirty_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        shadow_q <= wr_val;
      end
      if (commit) begin
        dirty_q <= 1'b0;
      end else if (wr_en) begin
        dirty_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_cmp_commit.sv
module pwm_cmp_commit
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_zero,
  input  upd_mode_e        mode,
  input  logic             glb_req,
  input  logic             dirty,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_val,
  input  logic [CMP_W-1:0] shadow,
  output logic             commit,
  output logic [CMP_W-1:0] active_q
);

  logic             sync_pend_q;
  logic             sync_ok;
  logic             has_new;
  logic [CMP_W-1:0] next_val;

  // A request seen at the zero edge itself also counts.
  assign sync_ok  = sync_pend_q | glb_req;
  assign has_new  = dirty | wr_en;
  assign commit   = cnt_zero & has_new & ((mode == UPD_IMMEDIATE) | sync_ok);
  // A write at the commit edge takes precedence over the stored shadow.
  assign next_val = wr_en ? wr_val : shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_pend_q <= 1'b0;
    end else if (cnt_zero) begin
      sync_pend_q <= 1'b0;
    end else if (glb_req) begin
      sync_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (commit) begin
      active_q <= next_val;
    end
  end

endmodule

// File: rtl/pwm_cmp_match.sv
module pwm_cmp_match #(
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CMP_W-1:0] cnt_val,
  input  logic [CMP_W-1:0] cnt_load,
  input  logic [CMP_W-1:0] active,
  output logic             match_q
);

  logic hit;
  logic reachable;

  assign hit       = (active == cnt_val);
  assign reachable = (active <= cnt_load);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
    end else begin
      match_q <= cnt_en & hit & reachable;
    end
  end

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CMP_W = CMP_W_DEF,
  parameter int unsigned REG_W = REG_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             upd_sync_mode,
  input  logic             glb_sync_req,
  input  logic             cnt_en,
  input  logic [CMP_W-1:0] cnt_val,
  input  logic [CMP_W-1:0] cnt_load,
  input  logic             cnt_zero,
  output logic             match_pulse
);

  localparam int unsigned PAD_W = REG_W - CMP_W;

  logic [CMP_W-1:0] wr_val;
  logic [CMP_W-1:0] shadow_val;
  logic [CMP_W-1:0] active_val;
  logic             dirty;
  logic             commit;
  logic             unused_hi;

  assign wr_val    = wr_data[CMP_W-1:0];
  assign unused_hi = ^wr_data[REG_W-1:CMP_W];

  pwm_cmp_shadow #(.CMP_W(CMP_W)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_val   (wr_val),
    .commit   (commit),
    .shadow_q (shadow_val),
    .dirty_q  (dirty)
  );

  pwm_cmp_commit #(.CMP_W(CMP_W)) u_commit (
    .clk      (clk),
    .rst      (rst),
    .cnt_zero (cnt_zero),
    .mode     (upd_mode_e'(upd_sync_mode)),
    .glb_req  (glb_sync_req),
    .dirty    (dirty),
    .wr_en    (wr_en),
    .wr_val   (wr_val),
    .shadow   (shadow_val),
    .commit   (commit),
    .active_q (active_val)
  );

  pwm_cmp_match #(.CMP_W(CMP_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .cnt_val  (cnt_val),
    .cnt_load (cnt_load),
    .active   (active_val),
    .match_q  (match_pulse)
  );

  assign rd_data = {{PAD_W{1'b0}}, shadow_val};

endmodule

// File: rtl/pwm_cmp_unit_chk.sv
module pwm_cmp_unit_chk #(
  parameter int unsigned CMP_W = 16,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             upd_sync_mode,
  input logic             cnt_en,
  input logic [CMP_W-1:0] cnt_val,
  input logic [CMP_W-1:0] cnt_load,
  input logic             cnt_zero,
  input logic             match_pulse,
  input logic [CMP_W-1:0] active_val
);

  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !match_pulse));

  assert_readback_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[CMP_W-1:0] == $past(wr_data[CMP_W-1:0]));

  assert_above_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_val > cnt_load) |=> !match_pulse);

  assert_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> !match_pulse);

  assert_zero_only_R7: assert property (@(posedge clk) disable iff (rst)
    !cnt_zero |=> $stable(active_val));

  assert_immediate_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && !upd_sync_mode) |=> active_val == rd_data[CMP_W-1:0]);

endmodule

bind pwm_cmp_unit pwm_cmp_unit_chk #(.CMP_W(CMP_W), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .upd_sync_mode (upd_sync_mode),
  .cnt_en        (cnt_en),
  .cnt_val       (cnt_val),
  .cnt_load      (cnt_load),
  .cnt_zero      (cnt_zero),
  .match_pulse   (match_pulse),
  .active_val    (active_val)
);

// File: tb/pwm_cmp_unit_bench.sv
`timescale 1ns/100ps
module pwm_cmp_unit_bench;

  typedef struct packed {
    logic [23:0] req;
    logic        wr;
    logic [31:0] wdata;
    logic        mode;
    logic        sreq;
    logic        en;
    logic [15:0] cv;
    logic [15:0] ld;
    logic        zero;
    logic        exp_m;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 26;
  // Fields: req, wr, wdata, mode, sreq, en, cv, ld, zero, exp_match, exp_rd
  localparam vec_t VECS [NV] = '{
    '{"R1 ", 1'b1, 32'h0001_0020, 1'b0, 1'b0, 1'b1, 16'h0005, 16'h0064, 1'b0, 1'b0, 16'h0020},
    '{"R7 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0020, 16'h0064, 1'b0, 1'b0, 16'h0020},
    '{"R4 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0000, 16'h0064, 1'b1, 1'b1, 16'h0020},
    '{"R7 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0020, 16'h0064, 1'b0, 1'b1, 16'h0020},
    '{"R6 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0020, 16'h0064, 1'b0, 1'b0, 16'h0020},
    '{"R3 ", 1'b1, 32'h0000_0030, 1'b0, 1'b0, 1'b1, 16'h0003, 16'h0064, 1'b0, 1'b0, 16'h0030},
    '{"R10", 1'b1, 32'h0000_0040, 1'b0, 1'b0, 1'b1, 16'h0004, 16'h0064, 1'b0, 1'b0, 16'h0040},
    '{"R7 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0000, 16'h0064, 1'b1, 1'b0, 16'h0040},
    '{"R10", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0030, 16'h0064, 1'b0, 1'b0, 16'h0040},
    '{"R10", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0040, 16'h0064, 1'b0, 1'b1, 16'h0040},
    '{"R3 ", 1'b1, 32'h0000_0050, 1'b1, 1'b0, 1'b1, 16'h0001, 16'h0064, 1'b0, 1'b0, 16'h0050},
    '{"R8 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0000, 16'h0064, 1'b1, 1'b0, 16'h0050},
    '{"R8 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0050, 16'h0064, 1'b0, 1'b0, 16'h0050},
    '{"R8 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0040, 16'h0064, 1'b0, 1'b1, 16'h0050},
    '{"R9 ", 1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 16'h0007, 16'h0064, 1'b0, 1'b0, 16'h0050},
    '{"R9 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0050, 16'h0064, 1'b0, 1'b0, 16'h0050},
    '{"R9 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0000, 16'h0064, 1'b1, 1'b0, 16'h0050},
    '{"R8 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0050, 16'h0064, 1'b0, 1'b1, 16'h0050},
    '{"R3 ", 1'b1, 32'h0000_0060, 1'b1, 1'b0, 1'b1, 16'h0002, 16'h0064, 1'b0, 1'b0, 16'h0060},
    '{"R9 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0000, 16'h0064, 1'b1, 1'b0, 16'h0060},
    '{"R9 ", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0050, 16'h0064, 1'b0, 1'b1, 16'h0060},
    '{"R11", 1'b1, 32'h0000_0090, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0080, 1'b1, 1'b0, 16'h0090},
    '{"R5 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0090, 16'h0080, 1'b0, 1'b0, 16'h0090},
    '{"R5 ", 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 16'h0090, 16'h0090, 1'b0, 1'b1, 16'h0090},
    '{"R11", 1'b1, 32'h0000_0011, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h0090, 1'b1, 1'b0, 16'h0011},
    '{"R11", 1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 16'h0011, 16'h0090, 1'b0, 1'b1, 16'h0011}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        upd_sync_mode = 1'b0;
  logic        glb_sync_req = 1'b0;
  logic        cnt_en = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [15:0] cnt_load = '0;
  logic        cnt_zero = 1'b0;
  logic        match_pulse;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwm_cmp_unit u_pwm_cmp_unit (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .upd_sync_mode (upd_sync_mode),
    .glb_sync_req  (glb_sync_req),
    .cnt_en        (cnt_en),
    .cnt_val       (cnt_val),
    .cnt_load      (cnt_load),
    .cnt_zero      (cnt_zero),
    .match_pulse   (match_pulse)
  );

  // Drive at the falling edge, let one rising edge pass, sample 1 ns later.
  task automatic step(input logic wr, input logic [31:0] wd, input logic md,
                      input logic sr, input logic en, input logic [15:0] cv,
                      input logic [15:0] ld, input logic zr);
    @(negedge clk);
    wr_en = wr; wr_data = wd; upd_sync_mode = md; glb_sync_req = sr;
    cnt_en = en; cnt_val = cv; cnt_load = ld; cnt_zero = zr;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [23:0] tag, input logic em, input logic [15:0] erd);
    checks++;
    if (match_pulse !== em || rd_data !== {16'h0, erd}) begin
      fails++;
      $display("FAIL %s: match=%b rd=%h expected match=%b rd=%h",
               tag, match_pulse, rd_data, em, {16'h0, erd});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R2: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R2 ", 1'b0, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].wdata, VECS[i].mode, VECS[i].sreq,
           VECS[i].en, VECS[i].cv, VECS[i].ld, VECS[i].zero);
      chk(VECS[i].req, VECS[i].exp_m, VECS[i].exp_rd);
    end

    // R9: latch a synchronous request, then write, then reset clears all
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 16'h0005, 16'h0090, 1'b0);
    chk("R9 ", 1'b0, 16'h0011);
    step(1'b1, 32'hABCD_0033, 1'b0, 1'b0, 1'b1, 16'h0006, 16'h0090, 1'b0);
    chk("R1 ", 1'b0, 16'h0033);
    // R2: reset while active value would otherwise match
    @(negedge clk);
    rst = 1'b1;
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 16'h0011, 16'h0090, 1'b0);
    chk("R2 ", 1'b0, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    // R2: active value is zero after reset
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0090, 1'b1);
    chk("R2 ", 1'b1, 16'h0000);
    step(1'b1, 32'h0000_0022, 1'b1, 1'b0, 1'b1, 16'h0003, 16'h0090, 1'b0);
    chk("R3 ", 1'b0, 16'h0022);
    // R9: the pre-reset request is gone, so this zero does not commit
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0090, 1'b1);
    chk("R9 ", 1'b1, 16'h0022);
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 16'h0022, 16'h0090, 1'b0);
    chk("R8 ", 1'b0, 16'h0022);

    // R5: boundary at the full-scale value
    step(1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 1'b1);
    chk("R11", 1'b1, 16'hFFFF);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
    chk("R5 ", 1'b1, 16'hFFFF);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFE, 1'b0);
    chk("R5 ", 1'b0, 16'hFFFF);
    // R4: pulse lasts one cycle once the counter moves on
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
    chk("R4 ", 1'b1, 16'hFFFF);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 1'b0);
    chk("R4 ", 1'b0, 16'hFFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule